// File: doc/BRIEF.md
# Three-way compare branch selector

This block resolves a 64-bit branch instruction that splits control flow three ways in a single step. It receives the two 32-bit halves of the instruction, the current value of the register the instruction names, and the address of the first half. The register value is treated as a signed integer and compared with zero. Each of the three outcomes (negative, zero, positive) has its own 16-bit displacement inside the instruction. The block picks the displacement for the outcome that occurred and forms the branch destination.

The first half carries a 6-bit major opcode in bits [31:26], a 5-bit subcode in bits [25:21], a 5-bit register index in bits [20:16], and the displacement for a negative operand in bits [15:0]. The second half carries the displacement for a zero operand in bits [31:16] and the displacement for a positive operand in bits [15:0]. The classification, the selection and the address addition are combinational. The taken strobe and the target are registered, so a result appears one clock after the instruction is presented. The register index is passed straight through so that the surrounding pipeline knows which register to read.

Top module: `tri_branch_sel`

## Requirements
- R1: While `rst` is high at a rising edge, `taken_o` is 0 and `target_o` is 0 after that edge, even if a matching instruction is presented at the same time.
- R2: If `valid_i` is 1, word0 bits [31:26] equal `OPCODE` (default 6'h3A) and word0 bits [25:21] equal `SUBCODE` (default 5'h07), then `taken_o` is 1 after the next rising edge.
- R3: If `valid_i` is 0, or either the opcode or the subcode differs, then `taken_o` is 0 after the next rising edge and `target_o` keeps its previous value.
- R4: When the operand read as a signed 64-bit number is below zero, the displacement used is word0 bits [15:0].
- R5: When the operand is exactly zero, the displacement used is word1 bits [31:16].
- R6: When the operand read as a signed number is above zero, the displacement used is word1 bits [15:0].
- R7: The registered target is `pc_i` plus the chosen displacement sign-extended to 64 bits and shifted left by 2, computed modulo 2^64.
- R8: `reg_idx_o` equals word0 bits [20:16] in the same cycle, with no register in between.
- R9: The displacement extremes are handled exactly: 16'h8000 moves the target back by 131072 bytes, 16'h7FFF moves it forward by 131068 bytes, and the sum wraps past either end of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | The instruction words on this cycle are meaningful |
| word0_i | input | 32 | First instruction half: opcode, subcode, register index, negative-case displacement |
| word1_i | input | 32 | Second instruction half: zero-case displacement (upper), positive-case displacement (lower) |
| operand_i | input | 64 | Value of the register named by the instruction |
| pc_i | input | 64 | Address of the first instruction half |
| reg_idx_o | output | 5 | Register index taken from the first half, combinational |
| taken_o | output | 1 | One-cycle strobe: a three-way branch was resolved |
| target_o | output | 64 | Resolved branch destination, held between branches |

## Verification
The bench goes after the operand values where a sign or zero test is easy to get wrong: zero itself, plus and minus one, and the most positive and most negative values. A design that tested only the sign bit would send zero to the positive path, and one that compared as unsigned would send negative values to the positive path. The displacements 16'h8000 and 16'h7FFF are combined with addresses at both ends of the space, which exposes zero-extension instead of sign-extension, a missing shift, and a truncated adder. Every other opcode and subcode is swept right after a real branch, so a loose decoder shows up as a spurious strobe, and a target register without an enable shows up as a changed target.

// File: rtl/tbs_pkg.sv
package tbs_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned OPC_W  = 6;
  localparam int unsigned SUB_W  = 5;
  localparam int unsigned RIDX_W = 5;
  localparam int unsigned DISP_W = 16;

  // Outcome of the signed compare against zero
  typedef enum logic [1:0] {
    CMP_LT = 2'd0,
    CMP_EQ = 2'd1,
    CMP_GT = 2'd2
  } cmp_class_e;

  // Field layout of the 64-bit instruction, first half in the upper 32 bits
  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic [SUB_W-1:0]  sub;
    logic [RIDX_W-1:0] reg_idx;
    logic [DISP_W-1:0] disp_neg;
    logic [DISP_W-1:0] disp_zero;
    logic [DISP_W-1:0] disp_pos;
  } br_fields_t;

endpackage

// File: rtl/tbs_decode.sv
module tbs_decode
  import tbs_pkg::*;
#(
  parameter logic [OPC_W-1:0] OPCODE  = 6'h3A,
  parameter logic [SUB_W-1:0] SUBCODE = 5'h07
) (
  input  logic              valid_i,
  input  logic [WORD_W-1:0] word0_i,
  input  logic [WORD_W-1:0] word1_i,
  output logic [RIDX_W-1:0] reg_idx_o,
  output logic [DISP_W-1:0] disp_neg_o,
  output logic [DISP_W-1:0] disp_zero_o,
  output logic [DISP_W-1:0] disp_pos_o,
  output logic              hit_o
);

  br_fields_t fields;

  assign fields      = br_fields_t'({word0_i, word1_i});
  assign reg_idx_o   = fields.reg_idx;
  assign disp_neg_o  = fields.disp_neg;
  assign disp_zero_o = fields.disp_zero;
  assign disp_pos_o  = fields.disp_pos;
  assign hit_o       = valid_i && (fields.opc == OPCODE) && (fields.sub == SUBCODE);

endmodule

// File: rtl/tbs_classify.sv
module tbs_classify
  import tbs_pkg::*;
#(
  parameter int unsigned OPERAND_W = 64
) (
  input  logic [OPERAND_W-1:0] operand_i,
  output cmp_class_e           cls_o
);

  logic is_neg;
  logic is_zero;

  assign is_neg  = operand_i[OPERAND_W-1];
  assign is_zero = ~|operand_i;

  always_comb begin
    if (is_neg)       cls_o = CMP_LT;
    else if (is_zero) cls_o = CMP_EQ;
    else              cls_o = CMP_GT;
  end

endmodule

// File: rtl/tbs_target.sv
module tbs_target
  import tbs_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned SHIFT  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit_i,
  input  cmp_class_e        cls_i,
  input  logic [DISP_W-1:0] disp_neg_i,
  input  logic [DISP_W-1:0] disp_zero_i,
  input  logic [DISP_W-1:0] disp_pos_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic              taken_o,
  output logic [ADDR_W-1:0] target_o
);

  localparam int unsigned EXT_W = ADDR_W - DISP_W;

  logic [DISP_W-1:0] disp_sel;
  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] next_target;

  always_comb begin
    unique case (cls_i)
      CMP_LT:  disp_sel = disp_neg_i;
      CMP_EQ:  disp_sel = disp_zero_i;
      default: disp_sel = disp_pos_i;
    endcase
  end

  assign disp_ext    = {{EXT_W{disp_sel[DISP_W-1]}}, disp_sel};
  assign offset      = disp_ext << SHIFT;
  assign next_target = pc_i + offset;

  always_ff @(posedge clk) begin
    if (rst) begin
      taken_o  <= 1'b0;
      target_o <= '0;
    end else begin
      taken_o <= hit_i;
      if (hit_i) target_o <= next_target;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!taken_o && target_o == '0)); // R1
  AST_HIT_STROBE: assert property (@(posedge clk) disable iff (rst) hit_i |=> taken_o); // R2
  AST_MISS_HOLD: assert property (@(posedge clk) disable iff (rst) !hit_i |=> (!taken_o && $stable(target_o))); // R3
  AST_TARGET_ALIGN: assert property (@(posedge clk) disable iff (rst) hit_i |=> (target_o[SHIFT-1:0] == $past(pc_i[SHIFT-1:0]))); // R7

endmodule

// File: rtl/tri_branch_sel.sv
module tri_branch_sel
  import tbs_pkg::*;
#(
  parameter int unsigned      ADDR_W    = 64,
  parameter int unsigned      OPERAND_W = 64,
  parameter int unsigned      SHIFT     = 2,
  parameter logic [OPC_W-1:0] OPCODE    = 6'h3A,
  parameter logic [SUB_W-1:0] SUBCODE   = 5'h07
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid_i,
  input  logic [WORD_W-1:0]    word0_i,
  input  logic [WORD_W-1:0]    word1_i,
  input  logic [OPERAND_W-1:0] operand_i,
  input  logic [ADDR_W-1:0]    pc_i,
  output logic [RIDX_W-1:0]    reg_idx_o,
  output logic                 taken_o,
  output logic [ADDR_W-1:0]    target_o
);

  logic              hit;
  logic [DISP_W-1:0] disp_neg;
  logic [DISP_W-1:0] disp_zero;
  logic [DISP_W-1:0] disp_pos;
  cmp_class_e        cls;

  tbs_decode #(
    .OPCODE  (OPCODE),
    .SUBCODE (SUBCODE)
  ) u_decode (
    .valid_i     (valid_i),
    .word0_i     (word0_i),
    .word1_i     (word1_i),
    .reg_idx_o   (reg_idx_o),
    .disp_neg_o  (disp_neg),
    .disp_zero_o (disp_zero),
    .disp_pos_o  (disp_pos),
    .hit_o       (hit)
  );

  tbs_classify #(
    .OPERAND_W (OPERAND_W)
  ) u_classify (
    .operand_i (operand_i),
    .cls_o     (cls)
  );

  tbs_target #(
    .ADDR_W (ADDR_W),
    .SHIFT  (SHIFT)
  ) u_target (
    .clk         (clk),
    .rst         (rst),
    .hit_i       (hit),
    .cls_i       (cls),
    .disp_neg_i  (disp_neg),
    .disp_zero_i (disp_zero),
    .disp_pos_i  (disp_pos),
    .pc_i        (pc_i),
    .taken_o     (taken_o),
    .target_o    (target_o)
  );

endmodule

// File: tb/test_tri_branch_sel.sv
`timescale 1ns/1ps
module test_tri_branch_sel;

  localparam logic [5:0] OPC = 6'h3A;
  localparam logic [4:0] SUB = 5'h07;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [31:0] word0_i = '0;
  logic [31:0] word1_i = '0;
  logic [63:0] operand_i = '0;
  logic [63:0] pc_i = '0;
  logic [4:0]  reg_idx_o;
  logic        taken_o;
  logic [63:0] target_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;
  logic [63:0] exp_tgt = '0;

  always #4 clk = ~clk;

  tri_branch_sel i_tri_branch_sel (
    .clk(clk), .rst(rst), .valid_i(valid_i), .word0_i(word0_i), .word1_i(word1_i),
    .operand_i(operand_i), .pc_i(pc_i), .reg_idx_o(reg_idx_o),
    .taken_o(taken_o), .target_o(target_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] calc_target(input logic [63:0] pc, input logic [31:0] w0,
                                              input logic [31:0] w1, input logic [63:0] op);
    logic [15:0] d;
    longint signed sop;
    longint signed sd;
    sop = $signed(op);
    if (sop < 0)       d = w0[15:0];
    else if (sop == 0) d = w1[31:16];
    else               d = w1[15:0];
    sd = longint'($signed(d));
    return pc + 64'(sd * 4);
  endfunction

  task automatic apply(input logic v, input logic [31:0] w0, input logic [31:0] w1,
                       input logic [63:0] op, input logic [63:0] pc, input logic exp_hit,
                       input string req);
    @(negedge clk);
    valid_i = v; word0_i = w0; word1_i = w1; operand_i = op; pc_i = pc;
    #1;
    chk("R8 reg index", 64'(reg_idx_o), 64'(w0[20:16]));
    if (exp_hit) exp_tgt = calc_target(pc, w0, w1, op);
    @(negedge clk);
    chk({req, " taken"}, 64'(taken_o), 64'(exp_hit));
    chk({req, " target"}, target_o, exp_tgt);
    valid_i = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] ops [7];
    logic [63:0] pcs [4];
    logic [47:0] dsets [3];
    ops[0] = 64'd0; ops[1] = 64'd1; ops[2] = 64'hFFFF_FFFF_FFFF_FFFF;
    ops[3] = 64'h7FFF_FFFF_FFFF_FFFF; ops[4] = 64'h8000_0000_0000_0000;
    ops[5] = 64'd2; ops[6] = 64'hFFFF_FFFF_FFFF_FFFE;
    pcs[0] = 64'h1000; pcs[1] = 64'h0;
    pcs[2] = 64'hFFFF_FFFF_FFFF_FFF0; pcs[3] = 64'h0000_0000_8000_0004;
    dsets[0] = {16'h0004, 16'h0010, 16'h0100};
    dsets[1] = {16'hFFFF, 16'h8000, 16'h7FFF};
    dsets[2] = {16'h1234, 16'hFEDC, 16'h0000};

    // R1: reset dominates a matching instruction
    valid_i = 1'b1; word0_i = {OPC, SUB, 5'd3, 16'h0040}; word1_i = 32'h0010_0020;
    operand_i = 64'd5; pc_i = 64'h4000;
    repeat (3) @(negedge clk);
    chk("R1 reset taken", 64'(taken_o), 64'd0);
    chk("R1 reset target", target_o, 64'd0);
    rst = 1'b0; valid_i = 1'b0;

    // R4 R5 R6 R7 R9: sweep operand classes, displacement extremes and addresses
    foreach (dsets[d]) begin
      for (int p = 0; p < 4; p++) begin
        for (int o = 0; o < 7; o++) begin
          apply(1'b1, {OPC, SUB, 5'(o + p), dsets[d][47:32]}, dsets[d][31:0],
                ops[o], pcs[p], 1'b1, "R4/R5/R6/R7/R9 select+add");
        end
      end
    end

    // R9: explicit wrap checks with computed constants
    apply(1'b1, {OPC, SUB, 5'd1, 16'h8000}, 32'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, "R9 neg wrap");
    chk("R9 neg wrap value", target_o, 64'hFFFF_FFFF_FFFE_0000);
    apply(1'b1, {OPC, SUB, 5'd1, 16'h0}, 32'h0000_7FFF, 64'd9, 64'hFFFF_FFFF_FFFF_FFFC, 1'b1, "R9 pos wrap");
    chk("R9 pos wrap value", target_o, 64'h0000_0000_0001_FFF8);

    // R3: every other opcode after a real branch
    for (int k = 0; k < 64; k++) begin
      if (6'(k) != OPC) begin
        apply(1'b1, {OPC, SUB, 5'd2, 16'h0008}, 32'h0, 64'd0 - 64'd1, 64'h2000 + 64'(k) * 64'h40, 1'b1, "R2 hit");
        apply(1'b1, {6'(k), SUB, 5'd2, 16'h0100}, 32'h0200_0300, 64'd7, 64'h9000, 1'b0, "R3 opcode mismatch");
      end
    end
    // R3: every other subcode
    for (int k = 0; k < 32; k++) begin
      if (5'(k) != SUB) begin
        apply(1'b1, {OPC, SUB, 5'd4, 16'h0}, 32'h0001_0000, 64'd0, 64'h3000 + 64'(k) * 64'h10, 1'b1, "R2 hit");
        apply(1'b1, {OPC, 5'(k), 5'd4, 16'h0100}, 32'h0200_0300, 64'd0, 64'h9000, 1'b0, "R3 subcode mismatch");
      end
    end
    // R3: valid low with a matching encoding
    apply(1'b0, {OPC, SUB, 5'd6, 16'h0100}, 32'h0200_0300, 64'd1, 64'h7777_0000, 1'b0, "R3 valid low");
    // R2: back-to-back branches
    apply(1'b1, {OPC, SUB, 5'd7, 16'h0001}, 32'h0002_0003, 64'd3, 64'h100, 1'b1, "R2 back-to-back a");
    apply(1'b1, {OPC, SUB, 5'd8, 16'h0001}, 32'h0002_0003, 64'd0, 64'h200, 1'b1, "R2 back-to-back b");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule